// File: doc/BRIEF.md
# Shutdown and Wake-up Controller

This controller sits in the always-on domain of a chip and runs from the 32 kHz slow clock, which keeps running while the core supply is off. When software issues a shutdown command, the controller waits a short entry window and then raises an output that turns off the core supply regulator. While the core is off it watches two wake-up sources: an external wake pin and an alarm line from the real-time clock. Software can enable each source on its own.

The wake pin reacts only to a transition into its programmed active level. The new level must survive a debounce filter whose length is chosen from five settings. The alarm reacts to a rising edge. A valid wake-up releases the supply-off output and holds the core in reset for a fixed number of slow cycles. The core then restarts from reset and does not resume. A wake-up that arrives during the entry window cancels the shutdown and goes straight to the reset. A status register records which source caused the last wake-up, and reading it clears it.

Top module: `shdn_wake_ctrl`

## Requirements
- R1: Writing a 1 to bit 0 at address 0 while running starts the entry window; `supply_off` rises exactly ENTRY_CYC slow-clock edges after the write edge.
- R2: A wake-up while the supply is off drops `supply_off` and raises `core_rst` on the same edge. `core_rst` stays high for exactly RST_CYC cycles, and the controller then returns to the running state.
- R3: The wake pin passes two synchronizer stages and then a debounce filter. Debounce code 0, 1, 2, 3 or 4 (higher codes act as 4) gives a hold length L of 0, 3, 32, 512 or 4096 cycles. A qualifying pin change wakes the core on the edge L+3 after the change. A level held for a shorter time is ignored.
- R4: Configuration bit 2 selects the active pin level (1 = high, 0 = low). Only a transition into the active level wakes the core.
- R5: A rising edge on `rtc_alarm` wakes the core on the first edge that samples it high.
- R6: A source whose enable bit is 0 (configuration bit 0 for the pin, bit 1 for the alarm) causes no wake-up. Events while running are also ignored and leave the status register unchanged.
- R7: Address 2 reads the wake status: bit 0 means the pin caused the wake, bit 1 means the alarm did. A read clears the register, so the next read returns 0.
- R8: A wake-up during the entry window cancels the shutdown. `core_rst` rises on the next edge and `supply_off` never asserts.
- R9: After power-on reset, `supply_off` and `core_rst` are 0, and the configuration (address 1, bits 5:0) and the status both read 0. `supply_off` and `core_rst` are never high together.
- R10: A pin that already sits at its active level when shutdown starts does not wake the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz always-on slow clock |
| rst_n | input | 1 | Power-on reset of the always-on domain, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status at address 2) |
| bus_addr | input | 2 | Register address: 0 command, 1 configuration, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| wake_pin | input | 1 | External wake-up pin, asynchronous |
| rtc_alarm | input | 1 | Alarm line from the real-time clock |
| supply_off | output | 1 | High disables the core supply regulator |
| core_rst | output | 1 | Reset to the core domain after a wake-up |

## Verification
Each result has a fixed due cycle. `supply_off` is due ENTRY_CYC edges after the command edge. An alarm takes effect on the next edge. A pin event takes effect L+3 edges after the pin changes, and the reset pulse lasts RST_CYC edges. The bench drives inputs and samples outputs on the falling clock edge. It counts rising edges up to exactly one cycle before each due edge, checks that the old value still holds there, and checks the new value right after the due edge. This is done for all five debounce lengths, both polarities, and the cancel-during-entry path.

// File: rtl/shdn_wake_ctrl.sv
module shdn_wake_ctrl #(
  parameter int ENTRY_CYC = 4,
  parameter int RST_CYC   = 8,
  parameter int DB_T1     = 3,
  parameter int DB_T2     = 32,
  parameter int DB_T3     = 512,
  parameter int DB_T4     = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       wake_pin,
  input  logic       rtc_alarm,
  output logic       supply_off,
  output logic       core_rst
);
  localparam int CW   = $clog2(DB_T4 + 1);
  localparam int PMAX = (ENTRY_CYC > RST_CYC) ? ENTRY_CYC : RST_CYC;
  localparam int PW   = $clog2(PMAX + 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_ENTER = 2'd1, S_OFF = 2'd2, S_RST = 2'd3} st_t;

  st_t           state;
  logic [PW-1:0] ph_cnt;
  logic [5:0]    cfg;
  logic [1:0]    status_q;
  logic [1:0]    pin_sync;
  logic          pin_db;
  logic [CW-1:0] db_cnt;
  logic [CW-1:0] db_lim;
  logic          alarm_q;

  wire cfg_pin_en   = cfg[0];
  wire cfg_alarm_en = cfg[1];
  wire cfg_pol      = cfg[2];
  wire pin_s        = pin_sync[1];
  wire pin_take     = (pin_s != pin_db) && (db_cnt == db_lim);
  wire pin_fire     = pin_take && (pin_s == cfg_pol) && cfg_pin_en;
  wire alarm_fire   = rtc_alarm && !alarm_q && cfg_alarm_en;
  wire sleeping     = (state == S_ENTER) || (state == S_OFF);
  wire wake         = sleeping && (pin_fire || alarm_fire);
  wire cmd_off      = bus_wr && (bus_addr == 2'd0) && bus_wdata[0] && (state == S_RUN);
  wire cfg_wr       = bus_wr && (bus_addr == 2'd1) && (state == S_RUN);
  wire stat_rd      = bus_rd && (bus_addr == 2'd2);
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[7:6];

  always_comb begin
    case (cfg[5:3])
      3'd0:    db_lim = '0;
      3'd1:    db_lim = CW'(DB_T1);
      3'd2:    db_lim = CW'(DB_T2);
      3'd3:    db_lim = CW'(DB_T3);
      default: db_lim = CW'(DB_T4);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync <= '0;
      pin_db   <= 1'b0;
      db_cnt   <= '0;
      alarm_q  <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], wake_pin};
      alarm_q  <= rtc_alarm;
      if (pin_take) begin
        pin_db <= pin_s;
        db_cnt <= '0;
      end else if (pin_s != pin_db) begin
        db_cnt <= db_cnt + 1'b1;
      end else begin
        db_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_RUN;
      ph_cnt <= '0;
    end else begin
      case (state)
        S_RUN:
          if (cmd_off) begin
            state  <= S_ENTER;
            ph_cnt <= '0;
          end
        S_ENTER:
          if (wake) begin
            state  <= S_RST;
            ph_cnt <= '0;
          end else if (ph_cnt == PW'(ENTRY_CYC - 1)) begin
            state  <= S_OFF;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        S_OFF:
          if (wake) begin
            state  <= S_RST;
            ph_cnt <= '0;
          end
        default:
          if (ph_cnt == PW'(RST_CYC - 1)) begin
            state  <= S_RUN;
            ph_cnt <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      status_q <= '0;
    end else begin
      if (cfg_wr) cfg <= bus_wdata[5:0];
      if (wake) status_q <= {alarm_fire, pin_fire};
      else if (stat_rd) status_q <= '0;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd1:    bus_rdata = {2'b00, cfg};
      2'd2:    bus_rdata = {6'b0, status_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign supply_off = (state == S_OFF);
  assign core_rst   = (state == S_RST);
endmodule

// File: rtl/shdn_wake_chk.sv
module shdn_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_off,
  input logic       core_rst,
  input logic [1:0] state,
  input logic [1:0] status,
  input logic       bus_rd,
  input logic [1:0] bus_addr
);
  // R9
  off_rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_off && core_rst));

  // R1
  off_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_off) |-> $past(state) == 2'd1);

  // R2
  exit_is_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_off) |-> core_rst);

  // R8
  rst_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> ($past(state) == 2'd1 || $past(state) == 2'd2));

  // R7
  rst_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> status != 2'b00);

  // R6
  run_status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && $past(state) == 2'd0 && !$past(bus_rd && bus_addr == 2'd2))
      |-> $stable(status));
endmodule

bind shdn_wake_ctrl shdn_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_off(supply_off), .core_rst(core_rst),
  .state(state), .status(status_q), .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/tb_shdn_wake_ctrl.sv
module tb_shdn_wake_ctrl;
  localparam int ENTRY_CYC = 4;
  localparam int RST_CYC   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic wake_pin = 1'b0, rtc_alarm = 1'b0;
  logic supply_off, core_rst;
  int total = 0, fails = 0, cyc = 0;

  shdn_wake_ctrl #(.ENTRY_CYC(ENTRY_CYC), .RST_CYC(RST_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_pin(wake_pin),
    .rtc_alarm(rtc_alarm), .supply_off(supply_off), .core_rst(core_rst));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int code);
    case (code)
      0: return 0;
      1: return 3;
      2: return 32;
      3: return 512;
      default: return 4096;
    endcase
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic enter_off();
    bus_write(2'd0, 8'h01);
    wait_cyc(ENTRY_CYC - 1);
    chk("R1 before due edge", supply_off, 0);
    wait_cyc(1);
    chk("R1 supply_off due", supply_off, 1);
  endtask

  task automatic check_reset_pulse();
    chk("R2 core_rst on wake", core_rst, 1);
    chk("R2 supply released", supply_off, 0);
    wait_cyc(RST_CYC - 1);
    chk("R2 core_rst held", core_rst, 1);
    wait_cyc(1);
    chk("R2 core_rst released", core_rst, 0);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R9 supply_off at reset", supply_off, 0);
    chk("R9 core_rst at reset", core_rst, 0);
    bus_read(2'd1, d);
    chk("R9 cfg at reset", d, 0);
    bus_read(2'd2, d);
    chk("R9 status at reset", d, 0);
  endtask

  task automatic t_alarm_wake();
    logic [7:0] d;
    bus_write(2'd1, 8'h02);
    bus_read(2'd1, d);
    chk("R9 cfg readback", d, 8'h02);
    enter_off();
    rtc_alarm = 1'b1;
    wait_cyc(1);
    chk("R5 alarm wakes next edge", core_rst, 1);
    check_reset_pulse();
    rtc_alarm = 1'b0;
    bus_read(2'd2, d);
    chk("R7 alarm status", d, 2);
    bus_read(2'd2, d);
    chk("R7 cleared by read", d, 0);
  endtask

  task automatic t_pin_wake(input int code);
    logic [7:0] d;
    int l;
    l = lim_of(code);
    bus_write(2'd1, 8'(8'h05 | (code << 3)));
    enter_off();
    wake_pin = 1'b1;
    wait_cyc(l + 2);
    chk($sformatf("R3 code %0d not yet", code), supply_off, 1);
    wait_cyc(1);
    chk($sformatf("R3 code %0d wake due", code), supply_off, 0);
    check_reset_pulse();
    wake_pin = 1'b0;
    wait_cyc(l + 5);
    bus_read(2'd2, d);
    chk("R7 pin status", d, 1);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    bus_write(2'd1, 8'h17);
    enter_off();
    wake_pin = 1'b1;
    wait_cyc(20);
    wake_pin = 1'b0;
    wait_cyc(60);
    chk("R3 short glitch ignored", supply_off, 1);
    rtc_alarm = 1'b1;
    wait_cyc(1);
    check_reset_pulse();
    rtc_alarm = 1'b0;
    bus_read(2'd2, d);
    chk("R3 glitch left no pin status", d, 2);
  endtask

  task automatic t_low_polarity();
    logic [7:0] d;
    bus_write(2'd1, 8'h01);
    wake_pin = 1'b1;
    wait_cyc(6);
    enter_off();
    wake_pin = 1'b0;
    wait_cyc(2);
    chk("R4 low level not yet", supply_off, 1);
    wait_cyc(1);
    chk("R4 falling pin wakes", core_rst, 1);
    wait_cyc(RST_CYC + 2);
    bus_read(2'd2, d);
    chk("R4 status pin", d, 1);
    enter_off();
    chk("R10 active pin at entry no wake", supply_off, 1);
    wake_pin = 1'b1;
    wait_cyc(10);
    chk("R4 rising pin ignored", supply_off, 1);
    wake_pin = 1'b0;
    wait_cyc(3);
    chk("R4 second falling wakes", core_rst, 1);
    wait_cyc(RST_CYC + 2);
    bus_read(2'd2, d);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    bus_write(2'd1, 8'h05);
    wait_cyc(4);
    rtc_alarm = 1'b1;
    wait_cyc(2);
    rtc_alarm = 1'b0;
    chk("R6 alarm in run no reset", core_rst, 0);
    bus_read(2'd2, d);
    chk("R6 run event no status", d, 0);
    enter_off();
    rtc_alarm = 1'b1;
    wait_cyc(10);
    rtc_alarm = 1'b0;
    chk("R6 disabled alarm ignored", supply_off, 1);
    wake_pin = 1'b1;
    wait_cyc(3);
    chk("R6 pin still wakes", core_rst, 1);
    wait_cyc(RST_CYC + 2);
    bus_read(2'd2, d);
    chk("R6 status pin only", d, 1);
    bus_write(2'd1, 8'h06);
    wake_pin = 1'b0;
    wait_cyc(4);
    enter_off();
    wake_pin = 1'b1;
    wait_cyc(10);
    chk("R6 disabled pin ignored", supply_off, 1);
    rtc_alarm = 1'b1;
    wait_cyc(1);
    chk("R6 alarm wakes", core_rst, 1);
    rtc_alarm = 1'b0;
    wait_cyc(RST_CYC + 2);
    bus_read(2'd2, d);
    chk("R6 status alarm only", d, 2);
    wake_pin = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_cancel();
    logic [7:0] d;
    bus_write(2'd1, 8'h02);
    bus_write(2'd0, 8'h01);
    rtc_alarm = 1'b1;
    wait_cyc(1);
    chk("R8 cancel gives reset", core_rst, 1);
    check_reset_pulse();
    rtc_alarm = 1'b0;
    chk("R8 supply never off", supply_off, 0);
    bus_read(2'd2, d);
    chk("R8 cancel status", d, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_alarm_wake();
    for (int c = 0; c < 5; c++) t_pin_wake(c);
    t_glitch();
    t_low_polarity();
    t_disabled();
    t_cancel();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule